// File: doc/BRIEF.md
# Modem Status Register with Change Flags

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) and presents them as one 8-bit status byte. The high nibble reports whether each line is currently asserted. The low nibble holds sticky flags that record changes on those lines since the byte was last read. When interrupts are enabled, any raised flag drives the modem-status interrupt.

The pins cross into the clock domain through a configurable synchroniser chain. Change detection then runs on the synchronised levels. The ring-indicator flag differs from the other three: it records only the end of ringing, when the pin returns high. It does not record the start of ringing.

A loopback mode feeds four modem-control outputs back as the line levels. In loopback the pins are ignored. A read strobe returns the byte and clears the flags. Address decoding belongs to the surrounding register file.

Top module: `modem_status_unit`

## Requirements
- R1: With loopback off, status bits 4, 5, 6 and 7 show the inverse of the synchronised CTS, DSR, RI and CD pins, in that order. A 1 means the line is asserted, which is a low pin. A pin change reaches the status byte SYNC_STAGES clock edges after it is sampled.
- R2: Flag bits 0, 1 and 3 are set one edge after the status bit of CTS, DSR or CD respectively changes in either direction.
- R3: Flag bit 2 is set only when the ring line goes from asserted to deasserted, which is the RI pin rising. An assertion of the ring line leaves bit 2 unchanged.
- R4: With loopback on, status bits 4, 5, 6 and 7 take the RTS, DTR, OUT1 and OUT2 control inputs respectively. Pin activity then changes neither the status bits nor the flags.
- R5: irq_o is 1 exactly when the interrupt enable is 1 and at least one flag bit is 1.
- R6: While rd_i is high, rd_data_o shows the flags before clearing. After that clock edge, every flag whose line did not change in the same cycle is 0.
- R7: A flag whose set condition falls on the same edge as a clearing read stays 1 after that edge.
- R8: After reset the flags are 0, irq_o is 0, and the synchronisers hold the deasserted (high) pin level, so the status nibble reads 0.
- R9: A set flag stays 1 for as long as no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| cd_n_i | input | 1 | Carrier detect pin, active low |
| rts_i | input | 1 | RTS control bit, loopback source for bit 4 |
| dtr_i | input | 1 | DTR control bit, loopback source for bit 5 |
| out1_i | input | 1 | OUT1 control bit, loopback source for bit 6 |
| out2_i | input | 1 | OUT2 control bit, loopback source for bit 7 |
| loop_i | input | 1 | Loopback enable |
| ien_i | input | 1 | Modem-status interrupt enable |
| rd_i | input | 1 | Register read strobe, clears flags |
| rd_data_o | output | 8 | Status nibble in bits 7:4, change flags in bits 3:0 |
| irq_o | output | 1 | Modem-status interrupt |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that the pin-to-status latency follows the parameter and is not fixed at two edges. The longer chain also widens the window in which a sweep of read offsets can place a clearing read before, on and after the edge where a flag sets. That sweep covers the read/set collision of R7 and the plain clear of R6.

// File: rtl/msr_pkg.sv
package msr_pkg;

   localparam int LINES = 4;

   typedef logic [LINES-1:0] line_vec_t;

   typedef enum logic [1:0] {
      LN_CTS  = 2'd0,
      LN_DSR  = 2'd1,
      LN_RING = 2'd2,
      LN_DCD  = 2'd3
   } line_e;

   typedef enum logic {
      EDGE_ANY   = 1'b0,
      EDGE_TRAIL = 1'b1
   } edge_e;

   function automatic edge_e edge_mode(input int idx);
      return (idx == int'(LN_RING)) ? EDGE_TRAIL : EDGE_ANY;
   endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_depth
      $error("msr_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("msr_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/msr_delta.sv
module msr_delta
   import msr_pkg::*;
#(
   parameter edge_e MODE = EDGE_ANY
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic clr_i,
   output logic flag_o
);

   logic prev_q;
   logic flag_q;
   logic set_w;

   if (MODE == EDGE_TRAIL) begin : g_trail
      assign set_w = prev_q & ~lvl_i;
   end else begin : g_any
      assign set_w = prev_q ^ lvl_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         flag_q <= (flag_q & ~clr_i) | set_w;
      end
   end

   assign flag_o = flag_q;

   // R9
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i |=> flag_q);

   // R6
   flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !set_w |=> !flag_q);

   // R7
   flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_w |=> flag_q);

   if (MODE == EDGE_TRAIL) begin : g_trail_chk
      // R3
      trail_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(flag_q) |-> ($past(prev_q) && !$past(lvl_i)));
   end else begin : g_any_chk
      // R2
      any_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(flag_q) |-> ($past(prev_q) != $past(lvl_i)));
   end

endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
   import msr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cts_n_i,
   input  logic       dsr_n_i,
   input  logic       ri_n_i,
   input  logic       cd_n_i,
   input  logic       rts_i,
   input  logic       dtr_i,
   input  logic       out1_i,
   input  logic       out2_i,
   input  logic       loop_i,
   input  logic       ien_i,
   input  logic       rd_i,
   output logic [7:0] rd_data_o,
   output logic       irq_o
);

   localparam int        BYTE_W   = 2 * LINES;
   localparam line_vec_t PIN_IDLE = '1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modem_status_unit: SYNC_STAGES must be at least 2");
   end
   if (BYTE_W != 8) begin : g_bad_lines
      $error("modem_status_unit: status byte must be 8 bits wide");
   end

   line_vec_t pin_raw;
   line_vec_t pin_sync;
   line_vec_t pin_lvl;
   line_vec_t ctl_lvl;
   line_vec_t cur_lvl;
   line_vec_t delta;

   assign pin_raw = {cd_n_i, ri_n_i, dsr_n_i, cts_n_i};
   assign ctl_lvl = {out2_i, out1_i, dtr_i, rts_i};

   msr_sync #(
      .W       (LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_raw),
      .q_o    (pin_sync)
   );

   assign pin_lvl = ~pin_sync;

   always_comb begin
      cur_lvl = pin_lvl;
      if (loop_i) cur_lvl = ctl_lvl;
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      msr_delta #(
         .MODE (edge_mode(i))
      ) u_delta (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .lvl_i  (cur_lvl[i]),
         .clr_i  (rd_i),
         .flag_o (delta[i])
      );
   end

   assign rd_data_o = {cur_lvl, delta};
   assign irq_o     = ien_i & (|delta);

   // R5
   irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_i && (rd_data_o[3:0] != 4'b0)) |-> irq_o);

   // R5
   irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (ien_i && (rd_data_o[3:0] != 4'b0)));

endmodule

// File: tb/modem_status_unit_bench.sv
module modem_status_unit_bench;

   localparam int STG = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
   logic rts = 1'b0, dtr = 1'b0, out1 = 1'b0, out2 = 1'b0;
   logic loopb = 1'b0, ien = 1'b0, rd = 1'b0;
   logic [7:0] rd_data;
   logic irq;

   modem_status_unit #(.SYNC_STAGES(STG)) u_modem_status_unit (
      .clk_i(clk), .rst_ni(rst_n),
      .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .cd_n_i(cd_n),
      .rts_i(rts), .dtr_i(dtr), .out1_i(out1), .out2_i(out2),
      .loop_i(loopb), .ien_i(ien), .rd_i(rd),
      .rd_data_o(rd_data), .irq_o(irq)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string tag = "R8";
   bit    done = 1'b0;

   task automatic chk(input string r, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // behavioural reference model
   logic [3:0] m_q[$];
   logic [3:0] m_prev = 4'h0;
   logic [3:0] m_dlt = 4'h0;

   function automatic logic [3:0] m_cur();
      if (loopb) return {out2, out1, dtr, rts};
      return ~m_q[0];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q.delete();
         for (int i = 0; i < STG; i++) m_q.push_back(4'hF);
         m_prev = 4'h0;
         m_dlt  = 4'h0;
      end else begin
         logic [3:0] c, s;
         c = m_cur();
         for (int i = 0; i < 4; i++)
            s[i] = (i == 2) ? (m_prev[i] && !c[i]) : (m_prev[i] != c[i]);
         m_dlt  = (rd ? 4'h0 : m_dlt) | s;
         m_prev = c;
         void'(m_q.pop_front());
         m_q.push_back({cd_n, ri_n, dsr_n, cts_n});
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done && m_q.size() == STG) begin
         chk(tag, rd_data, {m_cur(), m_dlt});
         chk(tag, irq, ien & (|m_dlt));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_read();
      rd = 1'b1;
      tick(1);
      rd = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (R1..all) actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8", rd_data, 8'h00);
      chk("R8", irq, 0);

      // R1 / R2: CTS asserts
      tag = "R1";
      tick(1);
      cts_n = 1'b0;
      tick(6);
      @(negedge clk);
      chk("R1", rd_data[7:4], 4'b0001);
      chk("R2", rd_data[3:0], 4'b0001);

      // R5 interrupt gating
      tag = "R5";
      tick(1);
      ien = 1'b1;
      @(negedge clk);
      chk("R5", irq, 1);
      tick(1);
      ien = 1'b0;
      @(negedge clk);
      chk("R5", irq, 0);

      // R9 sticky
      tag = "R9";
      tick(10);
      @(negedge clk);
      chk("R9", rd_data[0], 1);

      // R6 read returns then clears
      tag = "R6";
      tick(1);
      rd = 1'b1;
      @(negedge clk);
      chk("R6", rd_data[3:0], 4'b0001);
      tick(1);
      rd = 1'b0;
      @(negedge clk);
      chk("R6", rd_data[3:0], 4'b0000);

      // R3 ring: leading edge ignored, trailing edge flagged
      tag = "R3";
      tick(1);
      ri_n = 1'b0;
      tick(6);
      @(negedge clk);
      chk("R3", rd_data[3:0], 4'b0000);
      chk("R3", rd_data[7:4], 4'b0101);
      tick(1);
      ri_n = 1'b1;
      tick(6);
      @(negedge clk);
      chk("R3", rd_data[3:0], 4'b0100);
      tick(1);
      clear_read();

      // R2 DSR and CD together, then CTS deassert
      tag = "R2";
      dsr_n = 1'b0;
      cd_n  = 1'b0;
      tick(6);
      @(negedge clk);
      chk("R2", rd_data[3:0], 4'b1010);
      tick(1);
      clear_read();
      cts_n = 1'b1;
      tick(6);
      @(negedge clk);
      chk("R2", rd_data[3:0], 4'b0001);
      tick(1);
      clear_read();

      // R7 set on the same edge as a clearing read
      tag = "R7";
      tick(2);
      dsr_n = 1'b1;
      tick(STG);
      rd = 1'b1;
      tick(1);
      rd = 1'b0;
      @(negedge clk);
      chk("R7", rd_data[3:0], 4'b0010);
      tick(1);
      clear_read();
      for (int off = 0; off < 7; off++) begin
         cd_n = ~cd_n;
         tick(off);
         clear_read();
         tick(2);
      end
      tick(6);
      clear_read();

      // R4 loopback
      tag = "R4";
      loopb = 1'b1;
      rts   = 1'b1;
      out1  = 1'b1;
      tick(2);
      @(negedge clk);
      chk("R4", rd_data[7:4], 4'b0101);
      tick(1);
      clear_read();
      cts_n = ~cts_n;
      dsr_n = ~dsr_n;
      ri_n  = ~ri_n;
      cd_n  = ~cd_n;
      tick(6);
      @(negedge clk);
      chk("R4", rd_data, 8'h50);
      tick(1);
      out1 = 1'b0;
      tick(2);
      @(negedge clk);
      chk("R4", rd_data, 8'h14);
      tick(1);
      ien = 1'b1;
      dtr = 1'b1;
      out2 = 1'b1;
      tick(2);
      @(negedge clk);
      chk("R5", irq, 1);
      tick(1);
      clear_read();
      tick(2);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule